// File: doc/BRIEF.md
# Half-Duplex Encoder Transaction Sequencer

This block is the master-side sequencer for one request/response exchange with a position encoder over a half-duplex differential line. A start edge begins the exchange. The block then produces a programmed number of serial clocks while it drives the transceiver direction line high. Next it releases the line and waits, for any length of time, for the first falling edge of the encoder's reply. It then produces a second programmed number of clocks while the reply arrives, and returns to idle. Transmit data is meant to change on the falling clock edge. Receive data is meant to be sampled on the rising edge.

The serial clock comes from the system clock through a phase counter that spans one bit period (40 system clocks by default, which gives 2.5 MHz at 100 MHz). The cable delay is unknown and the encoder's bit rate can differ slightly from the master's. To absorb both, the phase counter restarts on every edge of the reply line while the block waits or receives. This places each rising sample edge about half a bit after the last line transition. An optional wait limit ends an exchange that gets no reply and flags it.

Top module: `enc_txn_seq`

## Requirements
- R1: After synchronous reset the state code is 00, busy, transmit enable and the no-reply flag are low, the serial clock is high and the clock count is zero.
- R2: A low-to-high change of the start input while idle begins an exchange. The state code becomes 01 and busy rises.
- R3: State codes are 00 idle, 01 sending, 10 waiting, 11 receiving. An answered exchange visits 01, 10, 11 and then 00. An unanswered exchange that times out visits 01, 10 and then 00.
- R4: Transmit enable is high exactly while the state is 01, for the transmit count times the bit period in system clocks, and the serial clock rises exactly transmit-count times in that span.
- R5: The serial clock idles high. Each bit starts with a falling edge. The first falling edge coincides with transmit enable rising. The rising edge comes half a bit period later. While sending, successive rising edges are one bit period apart.
- R6: While waiting, the serial clock stays high and does not toggle, however long the wait lasts.
- R7: A falling edge on the reply line while waiting moves the state to 11. The block then produces exactly receive-count rising edges before idling. The clock count then equals the sum of the transmit and receive counts.
- R8: Every reply-line edge while waiting or receiving restarts the bit phase. Rising edges therefore keep landing inside the encoder's bits when the encoder's bit period is a few clocks longer or shorter than the master's.
- R9: With a nonzero wait limit L and no reply, the block idles after exactly L clocks in state 10 and raises the no-reply flag. The flag holds until the next exchange starts. A limit of 0 means the block waits without bound.
- R10: Busy is high whenever the state is not 00. Start edges while busy are ignored and do not lengthen or restart the exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Exchange request; a rising edge while idle begins an exchange |
| tx_clks_i | input | 16 | Serial clocks to send (at least 1), latched at start |
| rx_clks_i | input | 16 | Serial clocks to receive (at least 1), used when the reply begins |
| wait_limit_i | input | 16 | Maximum clocks spent waiting for a reply; 0 disables the limit |
| resp_i | input | 1 | Reply line from the transceiver receiver, idle high |
| sclk_o | output | 1 | Serial bit clock, idle high |
| tx_en_o | output | 1 | Transceiver drive enable |
| busy_o | output | 1 | High while an exchange is in progress |
| state_o | output | 2 | Current state code |
| no_resp_o | output | 1 | Last exchange ended without a reply |
| clk_count_o | output | 16 | Serial clocks produced in the current or last exchange |

## Verification
A wrong phase or count register shows up within one bit period, as a misplaced rising edge or a wrong length of the transmit-enable window. A wrong target or a missed reply edge shows up at the end of the exchange, as a wrong final clock count or a missing return to idle. A broken realignment does not show up at once. With a mismatched encoder bit period it shows only after several bits, when the rising edges drift across bit boundaries and the sampled reply bits are corrupted. For that reason the bench sends long replies at periods both shorter and longer than the master's.

// File: rtl/enc_seq_pkg.sv
package enc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_SEND  = 2'b01,
        ST_AWAIT = 2'b10,
        ST_RECV  = 2'b11
    } seq_state_e;

    // States in which the serial clock toggles
    function automatic logic clocks_active(input seq_state_e s);
        return (s == ST_SEND) || (s == ST_RECV);
    endfunction

    // States in which reply-line edges realign the bit phase
    function automatic logic watches_line(input seq_state_e s);
        return (s == ST_AWAIT) || (s == ST_RECV);
    endfunction

endpackage

// File: rtl/enc_edge_det.sv
module enc_edge_det #(
    parameter int   SYNC_STAGES = 2,
    parameter logic RESET_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_i,
    output logic level_o,
    output logic change_o
);
    localparam int N = SYNC_STAGES + 1;

    logic [N-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= {N{RESET_LEVEL}};
        else     pipe <= {pipe[N-2:0], sig_i};
    end

    assign level_o  = pipe[N-2];
    assign change_o = pipe[N-2] ^ pipe[N-1];

endmodule

// File: rtl/enc_bitclk_gen.sv
module enc_bitclk_gen #(
    parameter int BIT_CLKS = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_i,
    input  logic run_i,
    input  logic align_i,
    output logic sclk_o,
    output logic rise_o,
    output logic bit_end_o
);
    localparam int HALF = BIT_CLKS / 2;
    localparam int PH_W = $clog2(BIT_CLKS);

    logic [PH_W-1:0] ph;
    logic            at_end;

    assign at_end = (ph == PH_W'(BIT_CLKS - 1));

    always_ff @(posedge clk) begin
        if (rst || hold_i)          ph <= '0;
        else if (align_i || at_end) ph <= '0;
        else                        ph <= ph + PH_W'(1);
    end

    assign sclk_o    = !(run_i && (ph < PH_W'(HALF)));
    assign rise_o    = run_i && (ph == PH_W'(HALF - 1));
    assign bit_end_o = at_end;

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (rst)
        ph < PH_W'(BIT_CLKS)); // R5

    AST_PHASE_HELD_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(hold_i) |-> (ph == '0)); // R2

endmodule

// File: rtl/enc_txn_fsm.sv
module enc_txn_fsm
    import enc_seq_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int WT_W  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_pulse_i,
    input  logic             resp_fall_i,
    input  logic             resp_edge_i,
    input  logic             rise_i,
    input  logic             bit_end_i,
    input  logic [CNT_W-1:0] tx_clks_i,
    input  logic [CNT_W-1:0] rx_clks_i,
    input  logic [WT_W-1:0]  wait_limit_i,
    output seq_state_e       state_o,
    output logic [CNT_W-1:0] count_o,
    output logic             no_resp_o
);
    seq_state_e       state;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] target;
    logic [WT_W-1:0]  wcnt;
    logic             no_resp;
    logic             at_target;

    assign at_target = (count == target);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            count   <= '0;
            target  <= '0;
            wcnt    <= '0;
            no_resp <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_pulse_i) begin
                        state   <= ST_SEND;
                        count   <= '0;
                        target  <= tx_clks_i;
                        no_resp <= 1'b0;
                    end
                end
                ST_SEND: begin
                    if (rise_i) count <= count + CNT_W'(1);
                    if (bit_end_i && at_target) begin
                        state <= ST_AWAIT;
                        wcnt  <= '0;
                    end
                end
                ST_AWAIT: begin
                    if (resp_fall_i) begin
                        state  <= ST_RECV;
                        target <= count + rx_clks_i;
                    end else if ((wait_limit_i != '0) &&
                                 (wcnt == wait_limit_i - WT_W'(1))) begin
                        state   <= ST_IDLE;
                        no_resp <= 1'b1;
                    end else begin
                        wcnt <= wcnt + WT_W'(1);
                    end
                end
                ST_RECV: begin
                    if (at_target) begin
                        if (bit_end_i || resp_edge_i) state <= ST_IDLE;
                    end else if (rise_i) begin
                        count <= count + CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign state_o   = state;
    assign count_o   = count;
    assign no_resp_o = no_resp;

    AST_SEND_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEND && $past(state) != ST_SEND) |-> $past(state) == ST_IDLE); // R2

    AST_AWAIT_FROM_SEND: assert property (@(posedge clk) disable iff (rst)
        (state == ST_AWAIT && $past(state) != ST_AWAIT) |-> $past(state) == ST_SEND); // R3

    AST_RECV_FROM_AWAIT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RECV && $past(state) != ST_RECV) |-> $past(state) == ST_AWAIT); // R7

    AST_SEND_ENDS_ON_COUNT: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_SEND && state == ST_AWAIT) |-> count == $past(target)); // R4

    AST_RECV_NO_OVERCOUNT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RECV && $past(state) == ST_RECV && $past(at_target)) |-> $stable(count)); // R7

    AST_NORESP_ON_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        $rose(no_resp) |-> ($past(state) == ST_AWAIT && state == ST_IDLE)); // R9

endmodule

// File: rtl/enc_txn_seq.sv
module enc_txn_seq
    import enc_seq_pkg::*;
#(
    parameter int BIT_CLKS    = 40,
    parameter int CNT_W       = 16,
    parameter int WT_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] tx_clks_i,
    input  logic [CNT_W-1:0] rx_clks_i,
    input  logic [WT_W-1:0]  wait_limit_i,
    input  logic             resp_i,
    output logic             sclk_o,
    output logic             tx_en_o,
    output logic             busy_o,
    output logic [1:0]       state_o,
    output logic             no_resp_o,
    output logic [CNT_W-1:0] clk_count_o
);
    logic       start_lvl, start_chg, start_pulse;
    logic       resp_lvl, resp_chg, resp_fall, align;
    logic       rise, bit_end;
    seq_state_e st;

    enc_edge_det #(.SYNC_STAGES(1), .RESET_LEVEL(1'b0)) u_start_edge (
        .clk      (clk),
        .rst      (rst),
        .sig_i    (start_i),
        .level_o  (start_lvl),
        .change_o (start_chg)
    );

    enc_edge_det #(.SYNC_STAGES(SYNC_STAGES), .RESET_LEVEL(1'b1)) u_resp_edge (
        .clk      (clk),
        .rst      (rst),
        .sig_i    (resp_i),
        .level_o  (resp_lvl),
        .change_o (resp_chg)
    );

    assign start_pulse = start_chg && start_lvl;
    assign resp_fall   = resp_chg && !resp_lvl;
    assign align       = resp_chg && watches_line(st);

    enc_bitclk_gen #(.BIT_CLKS(BIT_CLKS)) u_bitclk (
        .clk       (clk),
        .rst       (rst),
        .hold_i    (st == ST_IDLE),
        .run_i     (clocks_active(st)),
        .align_i   (align),
        .sclk_o    (sclk_o),
        .rise_o    (rise),
        .bit_end_o (bit_end)
    );

    enc_txn_fsm #(.CNT_W(CNT_W), .WT_W(WT_W)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .start_pulse_i (start_pulse),
        .resp_fall_i   (resp_fall),
        .resp_edge_i   (resp_chg),
        .rise_i        (rise),
        .bit_end_i     (bit_end),
        .tx_clks_i     (tx_clks_i),
        .rx_clks_i     (rx_clks_i),
        .wait_limit_i  (wait_limit_i),
        .state_o       (st),
        .count_o       (clk_count_o),
        .no_resp_o     (no_resp_o)
    );

    assign state_o = st;
    assign busy_o  = (st != ST_IDLE);
    assign tx_en_o = (st == ST_SEND);

    AST_SCLK_HIGH_WAIT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_AWAIT) |-> sclk_o); // R6

    AST_SCLK_HIGH_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> sclk_o); // R5

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_pulse && st != ST_SEND) |=> st != ST_SEND); // R10

endmodule

// File: tb/tb_enc_txn_seq.sv
module tb_enc_txn_seq;
    localparam int BIT  = 40;
    localparam int HALF = BIT / 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [15:0] tx_clks_i = 16'd1;
    logic [15:0] rx_clks_i = 16'd1;
    logic [15:0] wait_limit_i = 16'd0;
    logic        resp_i = 1'b1;
    logic        sclk_o, tx_en_o, busy_o, no_resp_o;
    logic [1:0]  state_o;
    logic [15:0] clk_count_o;

    always #10 clk = ~clk;

    enc_txn_seq #(.BIT_CLKS(BIT)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .tx_clks_i(tx_clks_i),
        .rx_clks_i(rx_clks_i), .wait_limit_i(wait_limit_i), .resp_i(resp_i),
        .sclk_o(sclk_o), .tx_en_o(tx_en_o), .busy_o(busy_o), .state_o(state_o),
        .no_resp_o(no_resp_o), .clk_count_o(clk_count_o)
    );

    typedef struct {
        int          tx;
        int          rx;
        int          limit;
        bit          respond;
        bit          poke;
        logic [63:0] bits;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_bad = 0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor state
    logic        p_busy = 0, p_sclk = 1, p_txen = 0;
    logic [1:0]  p_state = 0;
    logic [7:0]  seq = 0;
    logic [63:0] got = 0;
    int busy_cyc, txen_cyc, tx_r, rx_r, wait_f, bad_gap, cyc, last_rise, txen_start;
    bit first_rise, launch_ok;

    always @(negedge clk) begin
        if (!rst) begin
            if (busy_o && !p_busy) begin
                busy_cyc = 0; txen_cyc = 0; tx_r = 0; rx_r = 0; wait_f = 0;
                bad_gap = 0; cyc = 0; last_rise = 0; txen_start = 0;
                first_rise = 1; launch_ok = 0; seq = 0; got = 0;
            end
            if (state_o != p_state) seq = {seq[5:0], state_o};
            if (busy_o) begin busy_cyc++; cyc++; end
            if (tx_en_o) txen_cyc++;
            if (tx_en_o && !p_txen) begin launch_ok = (sclk_o == 1'b0); txen_start = cyc - 1; end
            if (sclk_o && !p_sclk && state_o == 2'b01) begin
                tx_r++;
                if (first_rise) begin
                    if (cyc - 1 - txen_start != HALF) bad_gap++;
                    first_rise = 0;
                end else if (cyc - last_rise != BIT) bad_gap++;
                last_rise = cyc;
            end
            if (sclk_o && !p_sclk && state_o == 2'b11) begin
                if (rx_r < 64) got[rx_r] = resp_i;
                rx_r++;
            end
            if (sclk_o != p_sclk && state_o == 2'b10 && p_state == 2'b10) wait_f++;
            if (!busy_o && p_busy) begin
                if (sb.size() == 0) chk("R3", "unexpected exchange", 1, 0);
                else begin
                    exp_t e;
                    logic [63:0] m;
                    e = sb.pop_front();
                    chk(e.poke ? "R10" : "R4", "tx enable cycles", txen_cyc, e.tx * BIT);
                    chk("R4", "rising edges while sending", tx_r, e.tx);
                    chk("R5", "launch fall with tx enable", launch_ok, 1);
                    chk("R5", "misplaced rising edges", bad_gap, 0);
                    chk("R6", "clock toggles while waiting", wait_f, 0);
                    if (e.respond) begin
                        m = (64'h1 << e.rx) - 64'h1;
                        chk("R2 R3", "state sequence", seq, 8'h6C);
                        chk("R7", "rising edges while receiving", rx_r, e.rx);
                        chk("R7", "final clock count", clk_count_o, e.tx + e.rx);
                        chk("R8", "sampled reply bits", got & m, e.bits & m);
                        chk("R9", "no-reply flag after answer", no_resp_o, 0);
                    end else begin
                        chk("R2 R3", "state sequence", seq, 8'h18);
                        chk("R9", "busy cycles with timeout", busy_cyc, e.tx * BIT + e.limit);
                        chk("R9", "no-reply flag after timeout", no_resp_o, 1);
                        chk("R9", "final clock count", clk_count_o, e.tx);
                        chk("R7", "rising edges while receiving", rx_r, 0);
                    end
                end
            end
            p_busy = busy_o; p_sclk = sclk_o; p_txen = tx_en_o; p_state = state_o;
        end
    end

    // Driver: pushes the expectation, starts the exchange, plays the encoder
    task automatic run_txn(input int tx, input int rx, input int limit, input int delay,
                           input int ebit, input logic [63:0] bits, input bit respond,
                           input bit poke);
        exp_t e;
        e.tx = tx; e.rx = rx; e.limit = limit; e.respond = respond; e.poke = poke; e.bits = bits;
        sb.push_back(e);
        tx_clks_i = 16'(tx); rx_clks_i = 16'(rx); wait_limit_i = 16'(limit);
        @(negedge clk); start_i = 1'b1;
        repeat (2) @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (60) @(negedge clk);
            start_i = 1'b1;
            repeat (2) @(negedge clk);
            start_i = 1'b0;
        end
        if (respond) begin
            while (state_o != 2'b10) @(negedge clk);
            repeat (delay) @(negedge clk);
            for (int i = 0; i < rx; i++) begin
                resp_i = bits[i];
                repeat (ebit) @(negedge clk);
            end
            resp_i = 1'b1;
        end
        while (!busy_o) @(negedge clk);
        while (busy_o) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    task automatic run_all();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "state code", state_o, 0);
        chk("R1", "busy", busy_o, 0);
        chk("R1", "tx enable", tx_en_o, 0);
        chk("R1", "serial clock", sclk_o, 1);
        chk("R1", "no-reply flag", no_resp_o, 0);
        chk("R1", "clock count", clk_count_o, 0);
        // Answered, matched period, long unbounded wait (limit 0)
        run_txn(1, 12, 0, 500, 40, 64'h0A5A, 1, 0);
        // Slow encoder bits, realignment needed (R8)
        run_txn(4, 20, 1000, 30, 42, 64'h6B3D4, 1, 0);
        // Fast encoder bits, start pulse while busy (R10)
        run_txn(8, 16, 0, 5, 38, 64'hC93A, 1, 1);
        // No reply, timeout (R9)
        run_txn(3, 4, 300, 0, 40, 64'h0, 0, 0);
        // Answered again: flag must clear
        run_txn(2, 24, 0, 100, 41, 64'h5CA9E6, 1, 0);
        // Shortest timeout
        run_txn(1, 4, 1, 0, 40, 64'h0, 0, 0);
        chk("R10", "busy after last exchange", busy_o, 0);
        chk("R3", "pending expectations", sb.size(), 0);
    endtask

    initial begin
        bit wd;
        wd = 0;
        fork
            run_all();
            begin repeat (150000) @(posedge clk); wd = 1; end
        join_any
        disable fork;
        if (wd) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule